// File: doc/BRIEF.md
# Reference-Counted Pad Power Sequencer

This block owns the three isolation controls of a pad power domain: a core-down line, an early clamp and a main clamp. Several clients may each ask for the pads to be powered. The block keeps a saturating reference count of those requests. Only the request that takes the count from zero to one powers the pads up, and only the release that takes it back to zero powers them down. Every other request is acknowledged at once and leaves the pads as they are.

Power-up releases the main clamp first, then the early clamp, and finally the core-down line. Power-down applies the same three steps in mirror order. Consecutive steps are separated by a gap counted in clock cycles. A sequence in progress raises `busy`, and requests that arrive while `busy` is high are dropped. A release with no matching request gives a one-cycle error pulse. A force-off request drops every outstanding reference in one go and leaves the pads fully isolated.

Requests are single-cycle pulses, sampled only while `busy` is low. When more than one request arrives in the same cycle, force-off wins over enable, and enable wins over disable.

Top module: `pad_pwr_seq`

## Requirements
- R1: After reset, `core_down`, `clamp_early` and `clamp_main` are all 1 (pads isolated), and `busy`, `en_ack`, `dis_ack` and `unbal_err` are all 0.
- R2: An enable request at count zero sets the count to one. In the next cycle `clamp_main` goes to 0 and `busy` goes to 1. `GAP_CYCLES` cycles later `clamp_early` goes to 0. After another `GAP_CYCLES` cycles `core_down` goes to 0, `en_ack` pulses for one cycle and `busy` returns to 0.
- R3: An enable request at a nonzero count increments the count. `en_ack` pulses in the next cycle, `busy` stays 0 and the pad outputs do not change.
- R4: A disable request at a count above one decrements the count. `dis_ack` pulses in the next cycle and the pad outputs do not change.
- R5: A disable request at count one sets the count to zero. In the next cycle `core_down` goes to 1. `GAP_CYCLES` cycles later `clamp_early` goes to 1. After another `GAP_CYCLES` cycles `clamp_main` goes to 1 and `dis_ack` pulses.
- R6: A disable request at count zero pulses `unbal_err` for one cycle in the next cycle. It gives no acknowledge and changes neither the count nor the pad outputs.
- R7: Requests of any kind that arrive while `busy` is 1 are ignored. They give no acknowledge and no error, and they do not change the count.
- R8: The count saturates at 2^`CNT_W`-1. Further enable requests are acknowledged as in R3 without changing the count, so exactly 2^`CNT_W`-1 disables are then needed to power down.
- R9: A force-off request at a nonzero count clears the count and runs the R5 power-down order, ending with `dis_ack`. At count zero it pulses `dis_ack` in the next cycle and changes nothing else.
- R10: When several requests arrive in the same cycle, force-off has priority over enable, and enable has priority over disable. The lower-priority requests are dropped.
- R11: `core_down` is 0 only while both clamps are 0. `clamp_early` is 0 only while `clamp_main` is 0. At most one pad output changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Enable (acquire) request pulse |
| dis_req | input | 1 | Disable (release) request pulse |
| force_off | input | 1 | Drop all references and isolate the pads |
| en_ack | output | 1 | One-cycle acknowledge of an enable |
| dis_ack | output | 1 | One-cycle acknowledge of a disable or force-off |
| unbal_err | output | 1 | One-cycle pulse on a disable at count zero |
| busy | output | 1 | A power sequence is running; requests are ignored |
| core_down | output | 1 | Core-down control, 1 = core powered down |
| clamp_early | output | 1 | Early clamp control, 1 = clamped |
| clamp_main | output | 1 | Main clamp control, 1 = clamped |

## Verification
The bench builds the block with `GAP_CYCLES` = 5 and `CNT_W` = 2, while the default gap is 20000 cycles. The short gap puts every step time of both orders, and a request injected mid-sequence, within a few cycles. The two-bit count saturates at 3, so five enables followed by exactly three disables tell saturation apart from wrap-around. The scoreboard predicts the exact cycle of every pad edge and every pulse.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_UP_A = 3'd1,
        SEQ_UP_B = 3'd2,
        SEQ_DN_A = 3'd3,
        SEQ_DN_B = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic core_down;
        logic clamp_early;
        logic clamp_main;
    } pad_ctl_t;

    localparam pad_ctl_t PADS_ISOLATED = '{core_down: 1'b1, clamp_early: 1'b1, clamp_main: 1'b1};

    typedef struct packed {
        seq_state_e st;
        pad_ctl_t   pads;
        logic       en_ack;
        logic       dis_ack;
        logic       err;
    } seq_regs_t;

endpackage

// File: rtl/pps_gap_timer.sv
module pps_gap_timer #(
    parameter int GAP_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int TW = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
    localparam logic [TW-1:0] LOAD = TW'(GAP_CYCLES - 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          run_d, run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start) begin
            cnt_d = LOAD;
            run_d = 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_d = 1'b0;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign expired = run_q && (cnt_q == '0);

    // R2 R5: a gap expires once and then stays quiet until restarted
    single_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !start) |=> !expired);

endmodule

// File: rtl/pps_refcnt.sv
module pps_refcnt #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic is_zero,
    output logic is_one
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                          cnt_d = '0;
        else if (inc && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        else if (dec && cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == CNT_W'(1));

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc && !clr) |=> (cnt_q == CNT_MAX));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && cnt_q == '0));

endmodule

// File: rtl/pad_pwr_seq.sv
module pad_pwr_seq #(
    parameter int GAP_CYCLES = 20000,
    parameter int CNT_W      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    input  logic force_off,
    output logic en_ack,
    output logic dis_ack,
    output logic unbal_err,
    output logic busy,
    output logic core_down,
    output logic clamp_early,
    output logic clamp_main
);
    import pps_pkg::*;

    seq_regs_t r_d, r_q;
    logic tmr_start, tmr_expired;
    logic cnt_inc, cnt_dec, cnt_clr, cnt_zero, cnt_one;

    pps_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    pps_refcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .dec     (cnt_dec),
        .clr     (cnt_clr),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    always_comb begin
        r_d         = r_q;
        r_d.en_ack  = 1'b0;
        r_d.dis_ack = 1'b0;
        r_d.err     = 1'b0;
        tmr_start   = 1'b0;
        cnt_inc     = 1'b0;
        cnt_dec     = 1'b0;
        cnt_clr     = 1'b0;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (force_off) begin
                    cnt_clr = 1'b1;
                    if (cnt_zero) begin
                        r_d.dis_ack = 1'b1;
                    end else begin
                        r_d.pads.core_down = 1'b1;
                        r_d.st             = SEQ_DN_A;
                        tmr_start          = 1'b1;
                    end
                end else if (en_req) begin
                    cnt_inc = 1'b1;
                    if (cnt_zero) begin
                        r_d.pads.clamp_main = 1'b0;
                        r_d.st              = SEQ_UP_A;
                        tmr_start           = 1'b1;
                    end else begin
                        r_d.en_ack = 1'b1;
                    end
                end else if (dis_req) begin
                    if (cnt_zero) begin
                        r_d.err = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                        if (cnt_one) begin
                            r_d.pads.core_down = 1'b1;
                            r_d.st             = SEQ_DN_A;
                            tmr_start          = 1'b1;
                        end else begin
                            r_d.dis_ack = 1'b1;
                        end
                    end
                end
            end
            SEQ_UP_A: if (tmr_expired) begin
                r_d.pads.clamp_early = 1'b0;
                r_d.st               = SEQ_UP_B;
                tmr_start            = 1'b1;
            end
            SEQ_UP_B: if (tmr_expired) begin
                r_d.pads.core_down = 1'b0;
                r_d.st             = SEQ_IDLE;
                r_d.en_ack         = 1'b1;
            end
            SEQ_DN_A: if (tmr_expired) begin
                r_d.pads.clamp_early = 1'b1;
                r_d.st               = SEQ_DN_B;
                tmr_start            = 1'b1;
            end
            SEQ_DN_B: if (tmr_expired) begin
                r_d.pads.clamp_main = 1'b1;
                r_d.st              = SEQ_IDLE;
                r_d.dis_ack         = 1'b1;
            end
            default: r_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= SEQ_IDLE;
            r_q.pads    <= PADS_ISOLATED;
            r_q.en_ack  <= 1'b0;
            r_q.dis_ack <= 1'b0;
            r_q.err     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != SEQ_IDLE);
    assign en_ack      = r_q.en_ack;
    assign dis_ack     = r_q.dis_ack;
    assign unbal_err   = r_q.err;
    assign core_down   = r_q.pads.core_down;
    assign clamp_early = r_q.pads.clamp_early;
    assign clamp_main  = r_q.pads.clamp_main;

    // R11
    core_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_down |-> (!clamp_early && !clamp_main));

    // R11
    clamp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_early |-> !clamp_main);

    // R11
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({core_down, clamp_early, clamp_main} ^
                   $past({core_down, clamp_early, clamp_main})) <= 1);

    // R1 R3: at rest the pads match the count
    rest_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cnt_zero ? (core_down && clamp_early && clamp_main)
                            : (!core_down && !clamp_early && !clamp_main)));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unbal_err |-> $stable({core_down, clamp_early, clamp_main}));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_ack, dis_ack, unbal_err}));

    // R7
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_expired) |=> !(en_ack || dis_ack || unbal_err));

endmodule

// File: tb/pad_pwr_seq_test.sv
`timescale 1ns/1ps
module pad_pwr_seq_test;
    localparam int GAP  = 5;
    localparam int CW   = 2;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, dis_req = 1'b0, force_off = 1'b0;
    logic en_ack, dis_ack, unbal_err, busy, core_down, clamp_early, clamp_main;

    pad_pwr_seq #(.GAP_CYCLES(GAP), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .force_off(force_off), .en_ack(en_ack), .dis_ack(dis_ack),
        .unbal_err(unbal_err), .busy(busy), .core_down(core_down),
        .clamp_early(clamp_early), .clamp_main(clamp_main)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          cyc;
        logic [5:0]  obs;
        string       tag;
    } ev_t;

    ev_t        exp_q[$];
    int         cyc = 0;
    int         total = 0;
    int         bad = 0;
    bit         mon_on = 1'b0;
    bit         finished = 1'b0;
    logic [2:0] prev_pads = 3'b111;
    int         mc = 0;
    logic [2:0] mp = 3'b111;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int c, input logic [2:0] p, input logic ea, input logic da,
                        input logic er, input string tag);
        ev_t e;
        e.cyc = c;
        e.obs = {p, ea, da, er};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: every edge or pulse on the outputs must match the next expected item.
    always @(negedge clk) begin
        if (mon_on) begin
            logic [5:0] obs;
            obs = {core_down, clamp_early, clamp_main, en_ack, dis_ack, unbal_err};
            if (obs[5:3] != prev_pads || |obs[2:0]) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected output event", {26'd0, obs}, 32'd0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(e.cyc == cyc, {e.tag, " event cycle"}, cyc, e.cyc);
                    chk(e.obs == obs, {e.tag, " event value"}, {26'd0, obs}, {26'd0, e.obs});
                end
            end
            prev_pads = obs[5:3];
        end
    end

    // Driver: one request pulse, predicted from the requirements.
    task automatic issue(input logic e, input logic d, input logic f, input bit poke, input string tag);
        int t0;
        int sq;
        sq = 0;
        @(negedge clk);
        en_req = e; dis_req = d; force_off = f;
        t0 = cyc + 1;
        if (f) begin
            if (mc == 0) push(t0, mp, 1'b0, 1'b1, 1'b0, tag);
            else begin mc = 0; sq = 2; end
        end else if (e) begin
            if (mc == 0) begin mc = 1; sq = 1; end
            else begin
                if (mc < MAXC) mc++;
                push(t0, mp, 1'b1, 1'b0, 1'b0, tag);
            end
        end else if (d) begin
            if (mc == 0) push(t0, mp, 1'b0, 1'b0, 1'b1, tag);
            else begin
                mc--;
                if (mc == 0) sq = 2;
                else push(t0, mp, 1'b0, 1'b1, 1'b0, tag);
            end
        end
        if (sq == 1) begin
            mp = 3'b110; push(t0, mp, 1'b0, 1'b0, 1'b0, tag);
            mp = 3'b100; push(t0 + GAP, mp, 1'b0, 1'b0, 1'b0, tag);
            mp = 3'b000; push(t0 + 2*GAP, mp, 1'b1, 1'b0, 1'b0, tag);
        end else if (sq == 2) begin
            mp = 3'b100; push(t0, mp, 1'b0, 1'b0, 1'b0, tag);
            mp = 3'b110; push(t0 + GAP, mp, 1'b0, 1'b0, 1'b0, tag);
            mp = 3'b111; push(t0 + 2*GAP, mp, 1'b0, 1'b1, 1'b0, tag);
        end
        @(negedge clk);
        en_req = 1'b0; dis_req = 1'b0; force_off = 1'b0;
        chk(busy == (sq != 0), {tag, " busy"}, {31'd0, busy}, {31'd0, sq != 0});
        if (sq != 0) begin
            if (poke) begin
                // R7: requests while busy must be dropped
                @(negedge clk);
                en_req = 1'b1; dis_req = 1'b1; force_off = 1'b1;
                @(negedge clk);
                en_req = 1'b0; dis_req = 1'b0; force_off = 1'b0;
            end
            while (cyc < t0 + 2*GAP + 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk({core_down, clamp_early, clamp_main} == 3'b111, "R1 pads isolated",
            {29'd0, core_down, clamp_early, clamp_main}, 32'h7);
        chk(busy == 1'b0, "R1 busy low", {31'd0, busy}, 32'd0);
        chk({en_ack, dis_ack, unbal_err} == 3'b000, "R1 no pulses",
            {29'd0, en_ack, dis_ack, unbal_err}, 32'd0);
        mon_on = 1'b1;

        issue(0, 1, 0, 0, "R6 unbalanced disable");
        issue(1, 0, 0, 1, "R2 first enable with R7 pokes");
        issue(1, 0, 0, 0, "R3 nested enable");
        issue(0, 1, 0, 0, "R4 nested disable");
        issue(0, 1, 0, 0, "R5 last disable");
        for (int i = 0; i < 5; i++) issue(1, 0, 0, 0, "R8 enable toward saturation");
        for (int i = 0; i < MAXC; i++) issue(0, 1, 0, 0, "R8 release from saturation");
        issue(0, 1, 0, 0, "R8 count back at zero");
        issue(1, 0, 0, 0, "R9 enable");
        issue(1, 0, 0, 0, "R9 enable");
        issue(0, 0, 1, 0, "R9 force-off");
        issue(0, 1, 0, 0, "R9 count cleared");
        issue(0, 0, 1, 0, "R9 force-off at zero");
        issue(1, 1, 0, 0, "R10 enable beats disable");
        issue(1, 0, 1, 0, "R10 force beats enable");
        issue(0, 1, 0, 0, "R10 count zero after force");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all predicted events seen", exp_q.size(), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule